// File: doc/BRIEF.md
# Cascaded Lookup Result Output Stage

This block is the result-output stage of one lookup device in a vertical cascade of such devices. Each lookup or memory cycle yields one address: a match address, the next free address, or a directly supplied random-access address. The stage captures that address with a response flag and shows it on a shared active-address bus. A page-address bus sits beside it and carries the device's configured page number. The lookup itself happens elsewhere. The addresses, the hit flag and the full flag arrive as inputs.

The stage has two register levels. A pending register takes the result of each finished cycle. A holding register copies that result to the outputs only while the enable strobe is high. While the strobe is low the outputs keep their value. Who drives the shared buses depends on the kind of cycle:
- **Arbitrated cycles** (compare, next-free write, highest-priority read/write). The device that responded drives, unless a higher-priority device already claimed the bus through the cascade hit chain. Output-enable does not matter here.
- **Misses.** When nothing responds, the device set as lowest-priority drives all ones.
- **Random-access cycles.** The addressed device drives under output-enable.

Top module: `casc_result_out`

## Requirements
- R1: Under reset and until the first result reaches the holding register, neither `act_addr` nor `page_addr` is driven (all bits Z). `hit_chain_out` equals `hit_chain_in`.
- R2: The cycle code `cyc_kind` selects the stored address. The codes are 0 compare and 2 highest-priority read/write, which take `match_addr`; 1 next-free write, which takes `free_addr`; and 3 random access, which takes `rand_addr`.
- R3: The holding register loads only on a clock edge where `strobe` is high. It then takes the result of a cycle finishing on that same edge (`cyc_done` high). Otherwise it takes the pending result from the most recent finished cycle. While `strobe` is low the outputs keep their value.
- R4: After an arbitrated cycle (codes 0, 1, 2), a device that responded drives `act_addr` when `hit_chain_in` is low. It does so whatever the state of `oe_n`. Responding means `hit` is high for codes 0 and 2, and `full` is low for code 1.
- R5: After an arbitrated cycle, while `hit_chain_in` is high, both output buses stay Z, even when `oe_n` is low.
- R6: After an arbitrated cycle, `hit_chain_out` is `hit_chain_in` OR the held response flag.
- R7: After a compare or highest-priority cycle with no hit, a device with `is_last` high and `hit_chain_in` low drives all ones. Without `is_last` it stays Z.
- R8: A next-free write with `full` high counts as a miss. The lowest device drives all ones.
- R9: After a random-access cycle, the buses are driven with `rand_addr` exactly when `rand_sel` was high for that cycle and `oe_n` is low. `hit_chain_out` passes `hit_chain_in` through.
- R10: `page_addr` is driven exactly when `act_addr` is driven. It carries `cfg_page` as sampled by the last strobe-qualified load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | Enable strobe; holding register loads while high |
| cyc_done | input | 1 | A lookup or memory cycle finishes this clock |
| cyc_kind | input | 2 | Cycle code: 0 compare, 1 next-free write, 2 highest-priority r/w, 3 random |
| hit | input | 1 | Match found in this device |
| full | input | 1 | No free entry in this device |
| rand_sel | input | 1 | This device is addressed by the random-access cycle |
| match_addr | input | 13 | Match address from the lookup |
| free_addr | input | 13 | Next free address |
| rand_addr | input | 13 | Random-access address |
| cfg_page | input | 4 | Configured page number |
| is_last | input | 1 | Device is lowest priority in the cascade |
| oe_n | input | 1 | Output enable, active low |
| hit_chain_in | input | 1 | A higher-priority device responded |
| hit_chain_out | output | 1 | This or a higher-priority device responded |
| act_addr | output | 13 | Active address bus, tri-state |
| page_addr | output | 4 | Page address bus, tri-state |

## Verification
A wrong response flag in the holding register shows on `hit_chain_out` in the same cycle that `hit_chain_in` goes low. It also shows as the bus being driven or released wrongly at that moment. A wrong stored cycle code shows as the bus following `oe_n` when it should not, or ignoring it when it should not. The reference model checks every clock, so a bad load, or a missed hold while the strobe is low, is caught on the first cycle after the edge where the holding register went wrong.

// File: rtl/casc_result_pkg.sv
package casc_result_pkg;
  typedef enum logic [1:0] {
    K_CMP = 2'd0,
    K_NFW = 2'd1,
    K_HPM = 2'd2,
    K_RND = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/casc_result_capture.sv
module casc_result_capture
  import casc_result_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_done,
  input  cyc_kind_e     kind_in,
  input  logic          hit,
  input  logic          full,
  input  logic          rand_sel,
  input  logic [AW-1:0] match_addr,
  input  logic [AW-1:0] free_addr,
  input  logic [AW-1:0] rand_addr,
  output cyc_kind_e     fresh_kind,
  output logic          fresh_resp,
  output logic [AW-1:0] fresh_addr,
  output cyc_kind_e     pend_kind,
  output logic          pend_resp,
  output logic [AW-1:0] pend_addr
);
  always_comb begin
    fresh_kind = kind_in;
    unique case (kind_in)
      K_NFW:   begin fresh_resp = !full;   fresh_addr = free_addr;  end
      K_RND:   begin fresh_resp = rand_sel; fresh_addr = rand_addr; end
      default: begin fresh_resp = hit;     fresh_addr = match_addr; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_kind <= K_RND;
      pend_resp <= 1'b0;
      pend_addr <= '0;
    end else if (cyc_done) begin
      pend_kind <= fresh_kind;
      pend_resp <= fresh_resp;
      pend_addr <= fresh_addr;
    end
  end

  a_r2_pending_tracks: assert property (@(posedge clk) disable iff (rst)
    (cyc_done && kind_in == K_NFW) |=> (pend_addr == $past(free_addr)));
endmodule

// File: rtl/casc_result_hold.sv
module casc_result_hold
  import casc_result_pkg::*;
#(
  parameter int AW = 13,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          cyc_done,
  input  cyc_kind_e     fresh_kind,
  input  logic          fresh_resp,
  input  logic [AW-1:0] fresh_addr,
  input  cyc_kind_e     pend_kind,
  input  logic          pend_resp,
  input  logic [AW-1:0] pend_addr,
  input  logic [PW-1:0] cfg_page,
  output cyc_kind_e     held_kind,
  output logic          held_resp,
  output logic [AW-1:0] held_addr,
  output logic [PW-1:0] held_page
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_kind <= K_RND;
      held_resp <= 1'b0;
      held_addr <= '0;
      held_page <= '0;
    end else if (strobe) begin
      held_page <= cfg_page;
      if (cyc_done) begin
        held_kind <= fresh_kind;
        held_resp <= fresh_resp;
        held_addr <= fresh_addr;
      end else begin
        held_kind <= pend_kind;
        held_resp <= pend_resp;
        held_addr <= pend_addr;
      end
    end
  end

  a_r3_hold_when_low: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(held_addr) && $stable(held_resp) && $stable(held_page)));
endmodule

// File: rtl/casc_result_arb.sv
module casc_result_arb
  import casc_result_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_kind_e     held_kind,
  input  logic          held_resp,
  input  logic [AW-1:0] held_addr,
  input  logic          is_last,
  input  logic          oe_n,
  input  logic          hit_chain_in,
  output logic          drive,
  output logic [AW-1:0] bus_val,
  output logic          hit_chain_out
);
  logic arbitrated;

  always_comb begin
    arbitrated = (held_kind != K_RND);
    if (arbitrated) begin
      hit_chain_out = hit_chain_in | held_resp;
      drive   = !hit_chain_in && (held_resp || is_last);
      bus_val = held_resp ? held_addr : {AW{1'b1}};
    end else begin
      hit_chain_out = hit_chain_in;
      drive   = held_resp && !oe_n;
      bus_val = held_addr;
    end
  end

  a_r5_yield_upstream: assert property (@(posedge clk) disable iff (rst)
    (held_kind != K_RND && hit_chain_in) |-> !drive);
  a_r9_random_needs_oe: assert property (@(posedge clk) disable iff (rst)
    (held_kind == K_RND && oe_n) |-> !drive);
  a_r6_chain_set: assert property (@(posedge clk) disable iff (rst)
    (held_kind != K_RND && held_resp) |-> hit_chain_out);
  a_r7_ones_only_last: assert property (@(posedge clk) disable iff (rst)
    (drive && bus_val == {AW{1'b1}} && !held_resp) |-> is_last);
endmodule

// File: rtl/casc_result_out.sv
module casc_result_out
  import casc_result_pkg::*;
#(
  parameter int AW = 13,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic          cyc_done,
  input  logic [1:0]    cyc_kind,
  input  logic          hit,
  input  logic          full,
  input  logic          rand_sel,
  input  logic [AW-1:0] match_addr,
  input  logic [AW-1:0] free_addr,
  input  logic [AW-1:0] rand_addr,
  input  logic [PW-1:0] cfg_page,
  input  logic          is_last,
  input  logic          oe_n,
  input  logic          hit_chain_in,
  output logic          hit_chain_out,
  output logic [AW-1:0] act_addr,
  output logic [PW-1:0] page_addr
);
  cyc_kind_e     fresh_kind, pend_kind, held_kind;
  logic          fresh_resp, pend_resp, held_resp;
  logic [AW-1:0] fresh_addr, pend_addr, held_addr, bus_val;
  logic [PW-1:0] held_page;
  logic          drive;

  casc_result_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst), .cyc_done(cyc_done), .kind_in(cyc_kind_e'(cyc_kind)),
    .hit(hit), .full(full), .rand_sel(rand_sel),
    .match_addr(match_addr), .free_addr(free_addr), .rand_addr(rand_addr),
    .fresh_kind(fresh_kind), .fresh_resp(fresh_resp), .fresh_addr(fresh_addr),
    .pend_kind(pend_kind), .pend_resp(pend_resp), .pend_addr(pend_addr)
  );

  casc_result_hold #(.AW(AW), .PW(PW)) u_hold (
    .clk(clk), .rst(rst), .strobe(strobe), .cyc_done(cyc_done),
    .fresh_kind(fresh_kind), .fresh_resp(fresh_resp), .fresh_addr(fresh_addr),
    .pend_kind(pend_kind), .pend_resp(pend_resp), .pend_addr(pend_addr),
    .cfg_page(cfg_page),
    .held_kind(held_kind), .held_resp(held_resp), .held_addr(held_addr),
    .held_page(held_page)
  );

  casc_result_arb #(.AW(AW)) u_arb (
    .clk(clk), .rst(rst), .held_kind(held_kind), .held_resp(held_resp),
    .held_addr(held_addr), .is_last(is_last), .oe_n(oe_n),
    .hit_chain_in(hit_chain_in), .drive(drive), .bus_val(bus_val),
    .hit_chain_out(hit_chain_out)
  );

  assign act_addr  = drive ? bus_val   : {AW{1'bz}};
  assign page_addr = drive ? held_page : {PW{1'bz}};

  a_r10_page_with_addr: assert property (@(posedge clk) disable iff (rst)
    drive |-> (page_addr == held_page));
endmodule

// File: tb/casc_result_out_test.sv
module casc_result_out_test;
  localparam int AW = 13;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 0, cyc_done = 0, hit = 0, full = 0, rand_sel = 0;
  logic [1:0] cyc_kind = 2'd3;
  logic [AW-1:0] match_addr = '0, free_addr = '0, rand_addr = '0;
  logic [PW-1:0] cfg_page = '0;
  logic is_last = 0, oe_n = 1, hit_chain_in = 0;
  logic hit_chain_out;
  logic [AW-1:0] act_addr;
  logic [PW-1:0] page_addr;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  casc_result_out #(.AW(AW), .PW(PW)) uut (
    .clk(clk), .rst(rst), .strobe(strobe), .cyc_done(cyc_done), .cyc_kind(cyc_kind),
    .hit(hit), .full(full), .rand_sel(rand_sel), .match_addr(match_addr),
    .free_addr(free_addr), .rand_addr(rand_addr), .cfg_page(cfg_page),
    .is_last(is_last), .oe_n(oe_n), .hit_chain_in(hit_chain_in),
    .hit_chain_out(hit_chain_out), .act_addr(act_addr), .page_addr(page_addr)
  );

  // reference model: pending and held results as plain integers
  int p_kind = 3, p_resp = 0, p_addr = 0;
  int h_kind = 3, h_resp = 0, h_addr = 0, h_page = 0;

  function automatic int f_resp();
    if (cyc_kind == 2'd1) return int'(!full);
    if (cyc_kind == 2'd3) return int'(rand_sel);
    return int'(hit);
  endfunction
  function automatic int f_addr();
    if (cyc_kind == 2'd1) return int'(free_addr);
    if (cyc_kind == 2'd3) return int'(rand_addr);
    return int'(match_addr);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      p_kind = 3; p_resp = 0; p_addr = 0;
      h_kind = 3; h_resp = 0; h_addr = 0; h_page = 0;
    end else begin
      if (strobe) begin
        h_page = int'(cfg_page);
        if (cyc_done) begin
          h_kind = int'(cyc_kind); h_resp = f_resp(); h_addr = f_addr();
        end else begin
          h_kind = p_kind; h_resp = p_resp; h_addr = p_addr;
        end
      end
      if (cyc_done) begin
        p_kind = int'(cyc_kind); p_resp = f_resp(); p_addr = f_addr();
      end
    end
  end

  task automatic compare(input string req);
    logic [AW-1:0] e_aa;
    logic [PW-1:0] e_pa;
    logic e_ho;
    bit drv;
    if (h_kind == 3) begin
      drv = (h_resp != 0) && !oe_n;
      e_ho = hit_chain_in;
    end else begin
      drv = !hit_chain_in && ((h_resp != 0) || is_last);
      e_ho = hit_chain_in || (h_resp != 0);
    end
    e_aa = !drv ? {AW{1'bz}} : ((h_kind != 3 && h_resp == 0) ? {AW{1'b1}} : AW'(h_addr));
    e_pa = drv ? PW'(h_page) : {PW{1'bz}};
    checks++;
    if (act_addr !== e_aa || page_addr !== e_pa || hit_chain_out !== e_ho) begin
      failures++;
      $display("FAIL %s t=%0t act=%h/%h page=%h/%h hout=%b/%b (actual/expected)",
               req, $time, act_addr, e_aa, page_addr, e_pa, hit_chain_out, e_ho);
    end
  endtask

  task automatic tick(input string req);
    #1 compare(req);
    @(negedge clk);
  endtask

  task automatic cyc(input logic [1:0] k, input logic h, input logic f, input logic s,
                     input logic st);
    cyc_kind = k; hit = h; full = f; rand_sel = s; strobe = st; cyc_done = 1;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    oe_n = 0; hit_chain_in = 0; is_last = 1;
    tick("R1"); tick("R1");
    rst = 0;
    tick("R1"); tick("R1");
    match_addr = 13'h0A5; free_addr = 13'h123; rand_addr = 13'h1F0; cfg_page = 4'h9;
    // compare hit with strobe high: drives regardless of oe_n
    oe_n = 1; is_last = 0;
    cyc(2'd0, 1, 0, 0, 1); tick("R2"); cyc_done = 0;
    tick("R4"); oe_n = 0; tick("R4");
    hit_chain_in = 1; tick("R5"); tick("R6");
    hit_chain_in = 0; tick("R6");
    // compare miss
    cyc(2'd0, 0, 0, 0, 1); tick("R7"); cyc_done = 0;
    tick("R7"); is_last = 1; tick("R7"); hit_chain_in = 1; tick("R7");
    hit_chain_in = 0;
    // next-free write: room, then full
    cyc(2'd1, 0, 0, 0, 1); tick("R2"); cyc_done = 0; tick("R2");
    cyc(2'd1, 0, 1, 0, 1); tick("R8"); cyc_done = 0; tick("R8");
    is_last = 0; tick("R8");
    // highest-priority read/write
    cyc(2'd2, 1, 0, 0, 1); tick("R2"); cyc_done = 0; tick("R2");
    // random access
    cyc(2'd3, 0, 0, 1, 1); tick("R9"); cyc_done = 0; tick("R9");
    oe_n = 1; tick("R9"); oe_n = 0; hit_chain_in = 1; tick("R9");
    hit_chain_in = 0;
    cyc(2'd3, 0, 0, 0, 1); tick("R9"); cyc_done = 0; tick("R9");
    // strobe low: new result must wait
    cyc(2'd0, 1, 0, 0, 0); match_addr = 13'h0777; cfg_page = 4'h3;
    tick("R3"); cyc_done = 0; tick("R3"); tick("R3");
    strobe = 1; tick("R3"); tick("R10"); strobe = 0;
    cfg_page = 4'hC; tick("R10"); strobe = 1; tick("R10"); tick("R10");
    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      cyc_kind = 2'($urandom_range(0, 3));
      hit = 1'($urandom); full = 1'($urandom); rand_sel = 1'($urandom);
      cyc_done = 1'($urandom); strobe = ($urandom_range(0, 3) != 0);
      oe_n = 1'($urandom); hit_chain_in = ($urandom_range(0, 3) == 0);
      is_last = 1'($urandom);
      match_addr = 13'($urandom); free_addr = 13'($urandom);
      rand_addr = 13'($urandom); cfg_page = 4'($urandom);
      if (i % 500 == 7) rst = 1; else rst = 0;
      tick("R3");
    end
    rst = 0;
    tick("R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule